// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block caches virtual-to-physical page translations for three page sizes: 4 KB, 2 MB and 1 GB. Each size has its own fully associative array and its own entry count. A lookup presents a 48-bit virtual address. In the same cycle, and without any clock edge, all three arrays compare their tags against it. The block returns a hit flag and a physical address. That address joins the cached physical page number to the untranslated low bits of the virtual address. The number of low bits depends on the page size that matched.

Translations come from a page walker outside the block. Once a miss has been resolved, the walker installs the translation through the fill port, with a size code naming the target array. A flush input drops every translation at once. Replacement works per array: a fill first reuses an entry that already holds the same page, then takes the lowest-numbered free entry, and only then evicts the entry that the array's round-robin pointer selects.

Top module: `mp_dtlb`

## Requirements
- R1: When a valid 4 KB entry matches `lookup_va_i[47:12]`, `hit_o` is 1 in the same cycle and `pa_o` = {cached page number, `lookup_va_i[11:0]`}.
- R2: A 2 MB entry matches on `lookup_va_i[47:21]` and passes `lookup_va_i[20:0]` through to `pa_o[20:0]`.
- R3: A 1 GB entry matches on `lookup_va_i[47:30]` and passes `lookup_va_i[29:0]` through to `pa_o[29:0]`.
- R4: When arrays of more than one size hit, the smallest page size supplies `pa_o`.
- R5: On a miss, `hit_o` is 0 and `pa_o` is 0, and the lookup changes no state.
- R6: `fill_size_i` selects the target array: 0 for 4 KB, 1 for 2 MB, 2 for 1 GB. Code 3 installs nothing. A fill takes effect at the clock edge on which `fill_valid_i` is high.
- R7: A fill writes the lowest-numbered invalid entry of its array, if there is one.
- R8: A fill into a full array replaces the entry at that array's round-robin pointer and advances only that pointer. The pointer wraps after the last entry.
- R9: A fill whose page is already resident in its array overwrites that entry's physical page number in place and evicts nothing.
- R10: The bits of `fill_va_i` and `fill_pa_i` below the page offset width are ignored.
- R11: `flush_i` invalidates every entry and resets every pointer in one cycle. It takes priority over a fill in the same cycle.
- R12: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_va_i | input | 48 | Virtual address to translate |
| hit_o | output | 1 | Translation found |
| pa_o | output | 40 | Translated physical address, 0 on a miss |
| fill_valid_i | input | 1 | Install a translation at this edge |
| fill_size_i | input | 2 | Page size code of the fill |
| fill_va_i | input | 48 | Virtual address of the page being filled |
| fill_pa_i | input | 40 | Physical address of the page being filled |
| flush_i | input | 1 | Invalidate all entries |

## Verification
A corrupted valid bit shows up on the very next lookup of that page. The port sees either a miss that should be a hit, or a hit that survived a flush. A wrong victim choice or a pointer that drifts stays hidden until later: it appears only when the array is full and the next fill evicts the wrong page. So the bench fills arrays to capacity, and then to capacity plus two, and checks which pages still resolve. A wrong offset width corrupts only the low address bits of a hit. The bench therefore uses lookup offsets that differ from the fill offsets.

// File: rtl/mp_dtlb_pkg.sv
package mp_dtlb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_NONE = 2'd3
  } pg_size_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               fill_en_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] same_page_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx, same_idx;
  logic             any_free, any_same;

  always_comb begin
    free_idx = '0;
    same_idx = '0;
    any_free = 1'b0;
    any_same = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
      if (same_page_i[i]) begin
        same_idx = IDX_W'(i);
        any_same = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_same)      victim_o = same_idx;
    else if (any_free) victim_o = free_idx;
    else               victim_o = ptr_q;
  end

  // pointer moves only when it actually picked the victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (flush_i) begin
      ptr_q <= '0;
    end else if (fill_en_i && !any_same && !any_free) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
      else                              ptr_q <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_size_array.sv
module tlb_size_array #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ENTRIES = 4,
  parameter int OFF_W   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            fill_en_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [PA_W-1:0] fill_pa_i,
  input  logic [VA_W-1:0] lk_va_i,
  output logic            hit_o,
  output logic [PA_W-1:0] pa_o
);
  localparam int TAG_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  logic [TAG_W-1:0]   lk_tag, fill_tag;
  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [PPN_W-1:0]   lk_ppn;
  logic [IDX_W-1:0]   victim;

  assign lk_tag   = lk_va_i[VA_W-1:OFF_W];
  assign fill_tag = fill_va_i[VA_W-1:OFF_W];

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_match[i]   = valid_q[i] && (tag_q[i] == lk_tag);
      fill_match[i] = valid_q[i] && (tag_q[i] == fill_tag);
      if (lk_match[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
  end

  assign hit_o = |lk_match;
  assign pa_o  = hit_o ? {lk_ppn, lk_va_i[OFF_W-1:0]} : '0;

  tlb_victim_sel #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush_i),
    .fill_en_i  (fill_en_i),
    .valid_i    (valid_q),
    .same_page_i(fill_match),
    .victim_o   (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_en_i) begin
      valid_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i && !flush_i) begin
      tag_q[victim] <= fill_tag;
      ppn_q[victim] <= fill_pa_i[PA_W-1:OFF_W];
    end
  end
endmodule

// File: rtl/mp_dtlb.sv
module mp_dtlb
  import mp_dtlb_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int N_4K   = 64,
  parameter int N_2M   = 32,
  parameter int N_1G   = 4,
  parameter int OFF_4K = 12,
  parameter int OFF_2M = 21,
  parameter int OFF_1G = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VA_W-1:0] lookup_va_i,
  output logic            hit_o,
  output logic [PA_W-1:0] pa_o,
  input  logic            fill_valid_i,
  input  logic [1:0]      fill_size_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic [PA_W-1:0] fill_pa_i,
  input  logic            flush_i
);
  localparam int ENT_A [NUM_SIZES] = '{N_4K, N_2M, N_1G};
  localparam int OFF_A [NUM_SIZES] = '{OFF_4K, OFF_2M, OFF_1G};

  logic [NUM_SIZES-1:0] hit_w;
  logic [PA_W-1:0]      pa_w [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    logic fill_en;
    assign fill_en = fill_valid_i && (fill_size_i == 2'(g)) && !flush_i;

    tlb_size_array #(
      .VA_W   (VA_W),
      .PA_W   (PA_W),
      .ENTRIES(ENT_A[g]),
      .OFF_W  (OFF_A[g])
    ) u_arr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flush_i  (flush_i),
      .fill_en_i(fill_en),
      .fill_va_i(fill_va_i),
      .fill_pa_i(fill_pa_i),
      .lk_va_i  (lookup_va_i),
      .hit_o    (hit_w[g]),
      .pa_o     (pa_w[g])
    );
  end

  // smallest page size wins
  always_comb begin
    pa_o = '0;
    for (int i = NUM_SIZES - 1; i >= 0; i--) begin
      if (hit_w[i]) pa_o = pa_w[i];
    end
  end

  assign hit_o = |hit_w;
endmodule

// File: rtl/mp_dtlb_chk.sv
module mp_dtlb_chk #(
  parameter int VA_W = 48,
  parameter int PA_W = 40
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [VA_W-1:0] lookup_va_i,
  input logic            hit_o,
  input logic [PA_W-1:0] pa_o,
  input logic            fill_valid_i,
  input logic [1:0]      fill_size_i,
  input logic [VA_W-1:0] fill_va_i,
  input logic [PA_W-1:0] fill_pa_i,
  input logic            flush_i
);
  // R11
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);

  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pa_o[11:0] == lookup_va_i[11:0]));

  // R5
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0));

  // R6
  fill_then_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && fill_size_i != 2'd3)
      |=> ((lookup_va_i != $past(fill_va_i)) || hit_o));

  // R5
  no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_valid_i && !flush_i) |=>
      ((lookup_va_i != $past(lookup_va_i)) || (hit_o == $past(hit_o))));
endmodule

bind mp_dtlb mp_dtlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/mp_dtlb_bench.sv
module mp_dtlb_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [47:0] lookup_va_i = '0;
  logic        hit_o;
  logic [39:0] pa_o;
  logic        fill_valid_i = 1'b0;
  logic [1:0]  fill_size_i = '0;
  logic [47:0] fill_va_i = '0;
  logic [39:0] fill_pa_i = '0;
  logic        flush_i = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  mp_dtlb u_mp_dtlb (.*);

  function automatic logic [39:0] xlat(input logic [39:0] fpa, input logic [47:0] va, input int ow);
    logic [39:0] m;
    m = (40'd1 << ow) - 40'd1;
    return (fpa & ~m) | (va[39:0] & m);
  endfunction

  task automatic look(input string req, input logic [47:0] va, input bit eh, input logic [39:0] ep);
    @(negedge clk_i);
    lookup_va_i = va;
    #1;
    n_run++;
    if (hit_o !== eh || (eh && pa_o !== ep) || (!eh && pa_o !== '0)) begin
      n_fail++;
      $display("FAIL %s va=%h hit=%0b pa=%h expected hit=%0b pa=%h", req, va, hit_o, pa_o, eh, eh ? ep : 40'd0);
    end
  endtask

  task automatic fill(input logic [1:0] sz, input logic [47:0] va, input logic [39:0] pa);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_size_i = sz; fill_va_i = va; fill_pa_i = pa;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  task automatic t_reset();
    look("R12", 48'h0000_0000_1000, 0, 0);
    look("R12", 48'h0000_4000_0000, 0, 0);
  endtask

  task automatic t_sizes();
    flush();
    fill(2'd0, 48'h0000_1234_5000, 40'h12_3456_7000);
    fill(2'd1, 48'h0000_0460_0000, 40'h00_ABC0_0000);
    fill(2'd2, 48'h0001_8000_0000, 40'h40_0000_0000);
    look("R1", 48'h0000_1234_5abc, 1, 40'h12_3456_7abc);
    look("R2", 48'h0000_047a_bcde, 1, xlat(40'h00_ABC0_0000, 48'h0000_047a_bcde, 21));
    look("R3", 48'h0001_b123_4567, 1, xlat(40'h40_0000_0000, 48'h0001_b123_4567, 30));
  endtask

  task automatic t_priority();
    flush();
    fill(2'd2, 48'h0000_4000_0000, 40'hC0_0000_0000);
    fill(2'd0, 48'h0000_4000_5000, 40'h00_1234_5000);
    look("R4", 48'h0000_4000_5abc, 1, 40'h00_1234_5abc);
    look("R4", 48'h0000_4000_6abc, 1, 40'hC0_0000_6abc);
  endtask

  task automatic t_miss();
    flush();
    fill(2'd0, 48'h0000_0000_3000, 40'h00_0000_9000);
    look("R5", 48'h0000_0000_4000, 0, 0);
    look("R5", 48'h0000_0000_3010, 1, 40'h00_0000_9010);
  endtask

  task automatic t_bad_size();
    flush();
    fill(2'd3, 48'h0000_0000_7000, 40'h00_0000_7000);
    look("R6", 48'h0000_0000_7000, 0, 0);
  endtask

  task automatic t_rr_1g();
    flush();
    for (int k = 8; k < 12; k++) fill(2'd2, 48'(k) << 30, 40'(k + 16) << 30);
    look("R7", 48'd11 << 30, 1, 40'd27 << 30);
    fill(2'd2, 48'd12 << 30, 40'd28 << 30);
    look("R8", 48'd8 << 30, 0, 0);
    fill(2'd2, 48'd13 << 30, 40'd29 << 30);
    look("R8", 48'd9 << 30, 0, 0);
    look("R8", 48'd10 << 30, 1, 40'd26 << 30);
    look("R8", 48'd13 << 30, 1, 40'd29 << 30);
  endtask

  task automatic t_full_4k();
    flush();
    for (int k = 0; k < 64; k++) fill(2'd0, 48'(k + 256) << 12, 40'(k + 512) << 12);
    fill(2'd0, 48'd261 << 12, 40'h77_7777_7000);
    look("R9", 48'd261 << 12, 1, 40'h77_7777_7000);
    look("R9", 48'd256 << 12, 1, 40'd512 << 12);
    fill(2'd0, 48'd900 << 12, 40'd901 << 12);
    look("R8", 48'd256 << 12, 0, 0);
    look("R8", 48'd257 << 12, 1, 40'd513 << 12);
    look("R8", 48'd900 << 12, 1, 40'd901 << 12);
  endtask

  task automatic t_offset_ignored();
    flush();
    fill(2'd1, 48'h0000_0a1f_ffff, 40'h01_201f_ffff);
    look("R10", 48'h0000_0a00_0001, 1, 40'h01_2000_0001);
  endtask

  task automatic t_flush();
    flush();
    fill(2'd0, 48'h0000_0000_5000, 40'h00_0000_5000);
    @(negedge clk_i);
    flush_i = 1'b1;
    fill_valid_i = 1'b1; fill_size_i = 2'd1; fill_va_i = 48'h0000_0800_0000; fill_pa_i = 40'h00_0800_0000;
    @(negedge clk_i);
    flush_i = 1'b0; fill_valid_i = 1'b0;
    look("R11", 48'h0000_0000_5000, 0, 0);
    look("R11", 48'h0000_0800_0000, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_sizes();
    t_priority();
    t_miss();
    t_bad_size();
    t_rr_1g();
    t_full_4k();
    t_offset_ignored();
    t_flush();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule